// File: doc/BRIEF.md
# Bulk List Endpoint Pointer Controller

This block holds the current-endpoint pointer that a USB host controller uses to walk its bulk transfer list in round-robin order. List processing raises `served` once it finishes an endpoint and presents that endpoint's next-link address. The pointer then moves on to that address. Because the pointer is never cleared at a frame boundary, the next frame resumes where the previous one stopped.

A zero pointer means the list is exhausted. At that point the block checks a list-filled flag. Software sets this flag when it adds work. If the flag is set, the block reloads the pointer from the head-pointer input and clears the flag. If the flag is clear, the pointer stays at zero. Software may overwrite the pointer only while bulk processing is disabled. While processing is enabled, software sees the live value.

Top module: `bulk_ep_ptr`

## Requirements
- R1: After reset `cur_ptr` is zero, `fill_flag` is 0 and `list_end` is 1.
- R2: Bits 3:0 of `cur_ptr` always read zero, and the low four bits of any written or loaded address are discarded.
- R3: With `bulk_en`=1, a `served` pulse loads `next_link` with bits 3:0 cleared into `cur_ptr` at the next clock edge. This takes priority over an end-of-list reload in the same cycle.
- R4: With `bulk_en`=1, `cur_ptr`=0 and `fill_flag`=0, the pointer stays zero.
- R5: With `bulk_en`=1, `cur_ptr`=0, `fill_flag`=1 and no `served`, the next edge copies `head_ptr` (bits 3:0 cleared) into `cur_ptr` and clears `fill_flag`. No reload occurs while `bulk_en`=0.
- R6: `sw_wr` loads `sw_wdata` only while `bulk_en`=0. While `bulk_en`=1 it is ignored.
- R7: `sw_fill_set`=1 sets `fill_flag` at the next edge. If a reload clears the flag in the same cycle, the set wins.
- R8: A `served` pulse whose `next_link` is zero loads zero. The end-of-list reload is evaluated on the following cycle.
- R9: `list_end` is 1 exactly when `cur_ptr` is zero and `fill_flag` is 0.
- R10: Without `served`, reload or an accepted write, `cur_ptr` holds its value. A `served` pulse while `bulk_en`=0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_wr | input | 1 | Software write strobe for the pointer |
| sw_wdata | input | 32 | Software write data |
| sw_fill_set | input | 1 | Software write of one to the list-filled flag |
| head_ptr | input | 32 | Bulk list head address |
| bulk_en | input | 1 | Bulk-list processing enable |
| served | input | 1 | Current endpoint served pulse |
| next_link | input | 32 | Next-link address of the served endpoint |
| cur_ptr | output | 32 | Current endpoint pointer; also the software read value |
| fill_flag | output | 1 | List-filled flag |
| list_end | output | 1 | End of list with no reload pending |

## Verification
The following are checked on every cycle:
- the advance on `served`;
- the head reload with its flag clear;
- the hold at zero with no flag;
- the write lockout while enabled;
- the set of the flag.

The bench's scenarios cover the rest:
- the set-beats-clear collision;
- the one-cycle gap between a zero-link advance and the reload that follows it;
- the absence of reloads while disabled;
- masking of the low bits across long sequences;
- the reset value.

// File: rtl/bulk_ep_ptr.sv
module bulk_ep_ptr #(
  parameter int PTR_W = 32,
  parameter int ALIGN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_wr,
  input  logic [PTR_W-1:0] sw_wdata,
  input  logic             sw_fill_set,
  input  logic [PTR_W-1:0] head_ptr,
  input  logic             bulk_en,
  input  logic             served,
  input  logic [PTR_W-1:0] next_link,
  output logic [PTR_W-1:0] cur_ptr,
  output logic             fill_flag,
  output logic             list_end
);

  localparam logic [PTR_W-1:0] KEEP = {{(PTR_W-ALIGN){1'b1}}, {ALIGN{1'b0}}};

  logic [PTR_W-1:0] ptr_q;
  logic             fill_q;

  wire at_end  = (ptr_q == '0);
  wire advance = bulk_en & served;
  wire reload  = bulk_en & ~served & at_end & fill_q;
  wire sw_load = ~bulk_en & sw_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      fill_q <= 1'b0;
    end else begin
      if (advance)      ptr_q <= next_link & KEEP;
      else if (reload)  ptr_q <= head_ptr & KEEP;
      else if (sw_load) ptr_q <= sw_wdata & KEEP;

      if (sw_fill_set)  fill_q <= 1'b1;
      else if (reload)  fill_q <= 1'b0;
    end
  end

  assign cur_ptr   = ptr_q;
  assign fill_flag = fill_q;
  assign list_end  = at_end & ~fill_q;

  // R2
  a_r2_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cur_ptr[ALIGN-1:0] == '0);

  a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (bulk_en && served) |=> cur_ptr == ($past(next_link) & KEEP));

  a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (bulk_en && !served && cur_ptr == '0 && fill_flag)
      |=> (cur_ptr == ($past(head_ptr) & KEEP)) && (fill_flag == $past(sw_fill_set)));

  a_r4_stay_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bulk_en && !served && cur_ptr == '0 && !fill_flag) |=> cur_ptr == '0);

  a_r6_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (bulk_en && !served && !(cur_ptr == '0 && fill_flag)) |=> $stable(cur_ptr));

  a_r7_set: assert property (@(posedge clk) disable iff (!rst_n)
    sw_fill_set |=> fill_flag);

endmodule

// File: tb/bulk_ep_ptr_tb.sv
module bulk_ep_ptr_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_wr = 1'b0;
  logic [31:0] sw_wdata = '0;
  logic        sw_fill_set = 1'b0;
  logic [31:0] head_ptr = '0;
  logic        bulk_en = 1'b0;
  logic        served = 1'b0;
  logic [31:0] next_link = '0;
  logic [31:0] cur_ptr;
  logic        fill_flag;
  logic        list_end;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  bulk_ep_ptr u_dut (
    .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
    .sw_fill_set(sw_fill_set), .head_ptr(head_ptr), .bulk_en(bulk_en),
    .served(served), .next_link(next_link), .cur_ptr(cur_ptr),
    .fill_flag(fill_flag), .list_end(list_end)
  );

  typedef struct packed {
    logic [23:0] tag;
    logic        en;
    logic        wr;
    logic        set;
    logic        srv;
    logic [31:0] wdata;
    logic [31:0] link;
    logic [31:0] head;
    logic [31:0] e_ptr;
    logic        e_flag;
    logic        e_end;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{"R2",  1'b0,1'b1,1'b0,1'b0, 32'h1234_5678, 32'h0, 32'h0, 32'h1234_5670, 1'b0, 1'b0},
    '{"R6",  1'b1,1'b1,1'b0,1'b0, 32'hAAAA_AAA0, 32'h0, 32'h0, 32'h1234_5670, 1'b0, 1'b0},
    '{"R3",  1'b1,1'b0,1'b0,1'b1, 32'h0, 32'h0000_2008, 32'h0, 32'h0000_2000, 1'b0, 1'b0},
    '{"R10", 1'b1,1'b0,1'b0,1'b0, 32'h0, 32'h0, 32'h0, 32'h0000_2000, 1'b0, 1'b0},
    '{"R10", 1'b0,1'b0,1'b0,1'b1, 32'h0, 32'h0000_3000, 32'h0, 32'h0000_2000, 1'b0, 1'b0},
    '{"R8",  1'b1,1'b0,1'b0,1'b1, 32'h0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b1},
    '{"R4",  1'b1,1'b0,1'b0,1'b0, 32'h0, 32'h0, 32'h0000_4000, 32'h0, 1'b0, 1'b1},
    '{"R7",  1'b1,1'b0,1'b1,1'b0, 32'h0, 32'h0, 32'h0000_4000, 32'h0, 1'b1, 1'b0},
    '{"R5",  1'b1,1'b0,1'b0,1'b0, 32'h0, 32'h0, 32'h0000_400C, 32'h0000_4000, 1'b0, 1'b0},
    '{"R9",  1'b1,1'b0,1'b0,1'b1, 32'h0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b1},
    '{"R9",  1'b1,1'b0,1'b1,1'b0, 32'h0, 32'h0, 32'h0, 32'h0, 1'b1, 1'b0},
    '{"R7",  1'b1,1'b0,1'b1,1'b0, 32'h0, 32'h0, 32'h0000_5000, 32'h0000_5000, 1'b1, 1'b0},
    '{"R8",  1'b1,1'b0,1'b0,1'b1, 32'h0, 32'h0, 32'h0000_6000, 32'h0, 1'b1, 1'b0},
    '{"R5",  1'b1,1'b0,1'b0,1'b0, 32'h0, 32'h0, 32'h0000_6000, 32'h0000_6000, 1'b0, 1'b0},
    '{"R6",  1'b0,1'b1,1'b0,1'b0, 32'h0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b1},
    '{"R5",  1'b0,1'b0,1'b1,1'b0, 32'h0, 32'h0, 32'h0000_7000, 32'h0, 1'b1, 1'b0},
    '{"R5",  1'b0,1'b0,1'b0,1'b0, 32'h0, 32'h0, 32'h0000_7000, 32'h0, 1'b1, 1'b0},
    '{"R3",  1'b1,1'b0,1'b0,1'b1, 32'h0, 32'h0000_800F, 32'h0000_7000, 32'h0000_8000, 1'b1, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] ep, input logic ef, input logic ee);
    n_chk++;
    if (cur_ptr !== ep || fill_flag !== ef || list_end !== ee) begin
      n_bad++;
      $display("FAIL %s: ptr=%h flag=%b end=%b expected ptr=%h flag=%b end=%b",
               req, cur_ptr, fill_flag, list_end, ep, ef, ee);
    end
  endtask

  task automatic idle_inputs();
    sw_wr = 0; sw_fill_set = 0; served = 0; bulk_en = 0;
    sw_wdata = '0; next_link = '0; head_ptr = '0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    check("R1", 32'h0, 1'b0, 1'b1);
    for (int i = 0; i < NV; i++) begin
      bulk_en = VEC[i].en; sw_wr = VEC[i].wr; sw_fill_set = VEC[i].set;
      served = VEC[i].srv; sw_wdata = VEC[i].wdata; next_link = VEC[i].link;
      head_ptr = VEC[i].head;
      @(posedge clk); #1;
      check($sformatf("%s vec%0d", VEC[i].tag, i), VEC[i].e_ptr, VEC[i].e_flag, VEC[i].e_end);
    end
    idle_inputs();
    @(posedge clk); #1;
    check("R10 idle hold", 32'h0000_8000, 1'b1, 1'b0);
    // R1: reset mid-run clears pointer and flag
    rst_n = 1'b0;
    @(posedge clk); #1;
    rst_n = 1'b1;
    check("R1 re-reset", 32'h0, 1'b0, 1'b1);
    // R2: all-ones write keeps low bits zero
    sw_wr = 1; sw_wdata = 32'hFFFF_FFFF;
    @(posedge clk); #1;
    idle_inputs();
    check("R2 ones", 32'hFFFF_FFF0, 1'b0, 1'b0);
    // R8: zero link then reload on the following cycle
    bulk_en = 1; sw_fill_set = 1;
    @(posedge clk); #1;
    sw_fill_set = 0; served = 1; next_link = 32'h0; head_ptr = 32'h0000_9000;
    @(posedge clk); #1;
    check("R8 zero link", 32'h0, 1'b1, 1'b0);
    served = 0;
    @(posedge clk); #1;
    check("R8 next-cycle reload", 32'h0000_9000, 1'b0, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule